// File: doc/BRIEF.md
# Secure Boot Policy Lock Sequencer

This block sequences the start-up of a microcontroller that may run a trusted first-stage program before its application. It follows three phases: the boot ROM runs, then (when the secure stage is configured) a privileged trusted stage runs, and finally the application runs locked. It requests a system reset at each phase change and supplies the fetch start address that the CPU uses after each reset.

While the trusted stage runs, three policy registers can be written: firewall settings, key-store protection and a bank-swap request. A write to the initialisation-done strobe ends the trusted stage. The block then requests a second system reset, drops privilege and freezes the policy registers until the next cold boot. The bank-swap select becomes effective only from that point, and only when both the secure-stage-present and the swap-allowed configuration bits are set. System resets that the block requests do not clear its own state. Only the synchronous cold boot reset does that.

Top module: `sbp_seq`

## Requirements
- R1: While `cold_rst` is high at a clock edge, the block enters the ROM phase. After that edge `sys_rst_req`, `privileged`, `init_done` and `bank_swap_sel` are 0, both policy outputs are zero, and `fetch_addr` equals `ROM_ENTRY` (default 0x1000_0000).
- R2: A `rom_done` pulse seen in the ROM phase raises `sys_rst_req` in the next cycle. `rom_done` has no effect in any other phase.
- R3: After every reset request that follows the ROM phase, `fetch_addr` equals `MAIN_BASE` + 4 (default 0x0000_0004).
- R4: If `cfg_secure` is 1 when the ROM phase completes, then from the reset-request cycle on `privileged` is 1 and `init_done` is 0.
- R5: If `cfg_secure` is 0 when the ROM phase completes, then from the reset-request cycle on `init_done` is 1 and `privileged` is 0, and no policy register ever accepts a write.
- R6: Policy writes (`fw_wr`, `ks_wr`, `swap_wr`) load their data only while `privileged` is 1. Writes in the ROM phase are ignored.
- R7: An `init_wr` pulse while privileged raises `sys_rst_req` in the next cycle. In that same cycle `init_done` becomes 1 and `privileged` becomes 0, and `fetch_addr` stays at the reset vector.
- R8: Once `init_done` is 1, writes to the firewall, key-store and bank-swap registers are ignored until the next cold boot.
- R9: `bank_swap_sel` is 1 only when all four of these hold: `init_done` is 1, `cfg_secure` is 1, `cfg_swap_en` is 1, and the swap register holds 1. The swap register is cleared by a cold boot.
- R10: `init_wr` outside the privileged phase is ignored and causes no reset request.
- R11: Only `cold_rst` clears `init_done` and the policy registers. Reset requests issued by the block leave them unchanged.
- R12: Each reset request is a single-cycle pulse registered on `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cold_rst | input | 1 | Synchronous active-high cold boot reset |
| rom_done | input | 1 | Boot ROM completion pulse |
| cfg_secure | input | 1 | Configuration: trusted secure stage present |
| cfg_swap_en | input | 1 | Configuration: bank swap permitted |
| init_wr | input | 1 | Write strobe setting initialisation-done |
| fw_wr | input | 1 | Firewall policy write strobe |
| fw_wdata | input | FW_W | Firewall policy write data |
| swap_wr | input | 1 | Bank-swap request write strobe |
| swap_wdata | input | 1 | Bank-swap request write data |
| ks_wr | input | 1 | Key-store protection write strobe |
| ks_wdata | input | KS_W | Key-store protection write data |
| sys_rst_req | output | 1 | Single-cycle system reset request |
| privileged | output | 1 | Trusted stage running with policy write permission |
| init_done | output | 1 | Initialisation-done status |
| bank_swap_sel | output | 1 | Effective bank-swap select |
| fetch_addr | output | ADDR_W | Fetch start address for the next reset |
| fw_policy | output | FW_W | Current firewall policy |
| ks_policy | output | KS_W | Current key-store protection policy |

## Verification
The bench writes the swap register and then checks that the select stays low until initialisation ends. A design that applied the swap early would start the first fetch from the wrong bank. It repeats `init_wr` and `rom_done` after the lock to catch a design that issues extra resets or reopens the registers, and it writes policies during the ROM phase and with the secure stage absent, where a loose write enable would let an attacker set policy. It also runs a cold boot after the lock to confirm that everything clears, including a swap register that a design might wrongly keep across boots, and it drops `cfg_swap_en` live to show that the select depends on both configuration bits.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    typedef enum logic [1:0] {
        PH_ROM    = 2'd0,
        PH_SECURE = 2'd1,
        PH_APP    = 2'd2
    } phase_e;

    localparam int unsigned RESET_VEC_OFS = 4;

    function automatic logic policy_open(input phase_e ph);
        return ph == PH_SECURE;
    endfunction

endpackage

// File: rtl/sbp_phase_fsm.sv
module sbp_phase_fsm
    import sbp_pkg::*;
(
    input  logic   clk,
    input  logic   cold_rst,
    input  logic   rom_done,
    input  logic   cfg_secure,
    input  logic   init_wr,
    output phase_e phase,
    output logic   sys_rst_req,
    output logic   init_done
);

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            phase       <= PH_ROM;
            sys_rst_req <= 1'b0;
            init_done   <= 1'b0;
        end else begin
            sys_rst_req <= 1'b0;
            unique case (phase)
                PH_ROM: begin
                    if (rom_done) begin
                        sys_rst_req <= 1'b1;
                        if (cfg_secure) begin
                            phase <= PH_SECURE;
                        end else begin
                            phase     <= PH_APP;
                            init_done <= 1'b1;
                        end
                    end
                end
                PH_SECURE: begin
                    if (init_wr) begin
                        sys_rst_req <= 1'b1;
                        init_done   <= 1'b1;
                        phase       <= PH_APP;
                    end
                end
                PH_APP: begin
                end
                default: phase <= PH_ROM;
            endcase
        end
    end

    // R12: reset request lasts one cycle
    p_pulse_single_r12: assert property (@(posedge clk) disable iff (cold_rst)
        sys_rst_req |=> !sys_rst_req);

    // R11: init_done only clears on cold boot
    p_done_sticky_r11: assert property (@(posedge clk) disable iff (cold_rst)
        init_done |=> init_done);

    // R10: init write once locked gives no reset
    p_no_rerun_r10: assert property (@(posedge clk) disable iff (cold_rst)
        (phase == PH_APP && init_wr) |=> !sys_rst_req);

    // R4: privileged stage never has init_done set
    p_priv_not_done_r4: assert property (@(posedge clk) disable iff (cold_rst)
        (phase == PH_SECURE) |-> !init_done);

    // R2: a reset request always follows a phase change out of the ROM or secure stage
    p_req_leaves_rom_r2: assert property (@(posedge clk) disable iff (cold_rst)
        sys_rst_req |-> (phase != PH_ROM));

endmodule

// File: rtl/sbp_lock_reg.sv
module sbp_lock_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         cold_rst,
    input  logic         open_i,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            q <= '0;
        end else if (open_i && wr) begin
            q <= wdata;
        end
    end

    // R8: a closed register holds its value
    p_frozen_r8: assert property (@(posedge clk) disable iff (cold_rst)
        !open_i |=> $stable(q));

endmodule

// File: rtl/sbp_fetch_map.sv
module sbp_fetch_map
    import sbp_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]  ROM_ENTRY = 32'h1000_0000,
    parameter logic [ADDR_W-1:0]  MAIN_BASE = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  phase_e            phase,
    input  logic              init_done,
    input  logic              cfg_secure,
    input  logic              cfg_swap_en,
    input  logic              swap_req,
    output logic              bank_swap_sel,
    output logic [ADDR_W-1:0] fetch_addr
);

    localparam logic [ADDR_W-1:0] MAIN_VEC = MAIN_BASE + ADDR_W'(RESET_VEC_OFS);

    always_comb begin
        fetch_addr    = (phase == PH_ROM) ? ROM_ENTRY : MAIN_VEC;
        bank_swap_sel = init_done && cfg_secure && cfg_swap_en && swap_req;
    end

    // R9: swap never effective before initialisation is done
    p_swap_after_init_r9: assert property (@(posedge clk) disable iff (cold_rst)
        bank_swap_sel |-> (init_done && phase == PH_APP));

    // R3: outside the ROM phase the reset vector is used
    p_vector_r3: assert property (@(posedge clk) disable iff (cold_rst)
        (phase != PH_ROM) |-> (fetch_addr == MAIN_VEC));

endmodule

// File: rtl/sbp_seq.sv
module sbp_seq
    import sbp_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 32,
    parameter int unsigned        FW_W      = 8,
    parameter int unsigned        KS_W      = 4,
    parameter logic [ADDR_W-1:0]  ROM_ENTRY = 32'h1000_0000,
    parameter logic [ADDR_W-1:0]  MAIN_BASE = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              rom_done,
    input  logic              cfg_secure,
    input  logic              cfg_swap_en,
    input  logic              init_wr,
    input  logic              fw_wr,
    input  logic [FW_W-1:0]   fw_wdata,
    input  logic              swap_wr,
    input  logic              swap_wdata,
    input  logic              ks_wr,
    input  logic [KS_W-1:0]   ks_wdata,
    output logic              sys_rst_req,
    output logic              privileged,
    output logic              init_done,
    output logic              bank_swap_sel,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [FW_W-1:0]   fw_policy,
    output logic [KS_W-1:0]   ks_policy
);

    phase_e     phase;
    logic       wr_open;
    logic [0:0] swap_q;

    sbp_phase_fsm u_fsm (
        .clk         (clk),
        .cold_rst    (cold_rst),
        .rom_done    (rom_done),
        .cfg_secure  (cfg_secure),
        .init_wr     (init_wr),
        .phase       (phase),
        .sys_rst_req (sys_rst_req),
        .init_done   (init_done)
    );

    assign wr_open    = policy_open(phase);
    assign privileged = wr_open;

    sbp_lock_reg #(.W(FW_W)) u_fw (
        .clk (clk), .cold_rst (cold_rst), .open_i (wr_open),
        .wr (fw_wr), .wdata (fw_wdata), .q (fw_policy)
    );

    sbp_lock_reg #(.W(KS_W)) u_ks (
        .clk (clk), .cold_rst (cold_rst), .open_i (wr_open),
        .wr (ks_wr), .wdata (ks_wdata), .q (ks_policy)
    );

    sbp_lock_reg #(.W(1)) u_swap (
        .clk (clk), .cold_rst (cold_rst), .open_i (wr_open),
        .wr (swap_wr), .wdata (swap_wdata), .q (swap_q)
    );

    sbp_fetch_map #(
        .ADDR_W (ADDR_W), .ROM_ENTRY (ROM_ENTRY), .MAIN_BASE (MAIN_BASE)
    ) u_map (
        .clk           (clk),
        .cold_rst      (cold_rst),
        .phase         (phase),
        .init_done     (init_done),
        .cfg_secure    (cfg_secure),
        .cfg_swap_en   (cfg_swap_en),
        .swap_req      (swap_q[0]),
        .bank_swap_sel (bank_swap_sel),
        .fetch_addr    (fetch_addr)
    );

    // R5: without a secure stage the policies stay at zero
    p_no_policy_r5: assert property (@(posedge clk) disable iff (cold_rst)
        (init_done && !cfg_secure) |-> (fw_policy == '0 || $stable(fw_policy)));

    // R6: policy registers change only while privileged
    p_write_window_r6: assert property (@(posedge clk) disable iff (cold_rst)
        !privileged |=> ($stable(fw_policy) && $stable(ks_policy)));

endmodule

// File: tb/sbp_seq_test.sv
`timescale 1ns/1ps
module sbp_seq_test;

    localparam logic [31:0] ROM_E = 32'h1000_0000;
    localparam logic [31:0] VEC   = 32'h0000_0004;

    logic        clk = 1'b0;
    logic        cold_rst, rom_done, cfg_secure, cfg_swap_en, init_wr;
    logic        fw_wr, swap_wr, swap_wdata, ks_wr;
    logic [7:0]  fw_wdata;
    logic [3:0]  ks_wdata;
    logic        sys_rst_req, privileged, init_done, bank_swap_sel;
    logic [31:0] fetch_addr;
    logic [7:0]  fw_policy;
    logic [3:0]  ks_policy;

    always #4 clk = ~clk;

    sbp_seq uut (
        .clk (clk), .cold_rst (cold_rst), .rom_done (rom_done),
        .cfg_secure (cfg_secure), .cfg_swap_en (cfg_swap_en), .init_wr (init_wr),
        .fw_wr (fw_wr), .fw_wdata (fw_wdata), .swap_wr (swap_wr),
        .swap_wdata (swap_wdata), .ks_wr (ks_wr), .ks_wdata (ks_wdata),
        .sys_rst_req (sys_rst_req), .privileged (privileged), .init_done (init_done),
        .bank_swap_sel (bank_swap_sel), .fetch_addr (fetch_addr),
        .fw_policy (fw_policy), .ks_policy (ks_policy)
    );

    typedef struct packed {
        logic       cold, rd, sec, swp, idw, fww, sww, swd, ksw;
        logic [7:0] fwd;
        logic [3:0] ksd;
    } in_t;

    typedef struct {
        string       tag;
        logic        req, priv, done, swap;
        logic [31:0] fetch;
        logic [7:0]  fw;
        logic [3:0]  ks;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    function automatic in_t idle(input logic sec, input logic swp);
        in_t i;
        i = '0;
        i.sec = sec;
        i.swp = swp;
        return i;
    endfunction

    function automatic exp_t ex(input string tag, input logic req, input logic priv,
                                input logic done, input logic swap, input logic [31:0] fetch,
                                input logic [7:0] fw, input logic [3:0] ks);
        exp_t e;
        e.tag = tag; e.req = req; e.priv = priv; e.done = done;
        e.swap = swap; e.fetch = fetch; e.fw = fw; e.ks = ks;
        return e;
    endfunction

    // driver: applies inputs for one cycle, queues the state expected after the edge
    task automatic drive(input in_t i, input exp_t e);
        @(negedge clk);
        cold_rst = i.cold; rom_done = i.rd; cfg_secure = i.sec; cfg_swap_en = i.swp;
        init_wr = i.idw; fw_wr = i.fww; fw_wdata = i.fwd; swap_wr = i.sww;
        swap_wdata = i.swd; ks_wr = i.ksw; ks_wdata = i.ksd;
        @(posedge clk);
        #1;
        q.push_back(e);
    endtask

    // monitor: compares outputs with queued expectations
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (sys_rst_req !== e.req || privileged !== e.priv || init_done !== e.done ||
                    bank_swap_sel !== e.swap || fetch_addr !== e.fetch ||
                    fw_policy !== e.fw || ks_policy !== e.ks) begin
                    n_bad++;
                    $display("FAIL %s: got req=%b priv=%b done=%b swap=%b fetch=%h fw=%h ks=%h, expected req=%b priv=%b done=%b swap=%b fetch=%h fw=%h ks=%h",
                             e.tag, sys_rst_req, privileged, init_done, bank_swap_sel,
                             fetch_addr, fw_policy, ks_policy, e.req, e.priv, e.done,
                             e.swap, e.fetch, e.fw, e.ks);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        in_t i;
        cold_rst = 1'b1; rom_done = 0; cfg_secure = 1; cfg_swap_en = 1; init_wr = 0;
        fw_wr = 0; fw_wdata = 0; swap_wr = 0; swap_wdata = 0; ks_wr = 0; ks_wdata = 0;

        // R1: cold boot state
        i = idle(1, 1); i.cold = 1;
        drive(i, ex("R1 cold", 0, 0, 0, 0, ROM_E, 8'h00, 4'h0));
        drive(i, ex("R1 cold hold", 0, 0, 0, 0, ROM_E, 8'h00, 4'h0));
        // R10 init write in ROM ignored, R6 policy write in ROM ignored
        i = idle(1, 1); i.idw = 1; i.fww = 1; i.fwd = 8'h77;
        drive(i, ex("R10/R6 ROM writes", 0, 0, 0, 0, ROM_E, 8'h00, 4'h0));
        // R2 R3 R4: ROM completes with secure stage present
        i = idle(1, 1); i.rd = 1;
        drive(i, ex("R2/R3/R4 rom done", 1, 1, 0, 0, VEC, 8'h00, 4'h0));
        i = idle(1, 1);
        drive(i, ex("R12 pulse ends", 0, 1, 0, 0, VEC, 8'h00, 4'h0));
        i = idle(1, 1); i.rd = 1;
        drive(i, ex("R2 rom done ignored", 0, 1, 0, 0, VEC, 8'h00, 4'h0));
        // R6 policy writes while privileged, R9 swap not yet effective
        i = idle(1, 1); i.fww = 1; i.fwd = 8'hA5; i.ksw = 1; i.ksd = 4'h9; i.sww = 1; i.swd = 1;
        drive(i, ex("R6/R9 priv writes", 0, 1, 0, 0, VEC, 8'hA5, 4'h9));
        // R7 init done
        i = idle(1, 1); i.idw = 1;
        drive(i, ex("R7/R9 init done", 1, 0, 1, 1, VEC, 8'hA5, 4'h9));
        i = idle(1, 1);
        drive(i, ex("R12/R11 after second reset", 0, 0, 1, 1, VEC, 8'hA5, 4'h9));
        // R8 locked writes
        i = idle(1, 1); i.fww = 1; i.fwd = 8'h3C; i.ksw = 1; i.ksd = 4'h2; i.sww = 1; i.swd = 0;
        drive(i, ex("R8 locked writes", 0, 0, 1, 1, VEC, 8'hA5, 4'h9));
        // R10 repeated init write
        i = idle(1, 1); i.idw = 1;
        drive(i, ex("R10 repeat init", 0, 0, 1, 1, VEC, 8'hA5, 4'h9));
        i = idle(1, 1); i.rd = 1;
        drive(i, ex("R2 rom done in app", 0, 0, 1, 1, VEC, 8'hA5, 4'h9));
        // R9 swap needs cfg_swap_en
        i = idle(1, 0);
        drive(i, ex("R9 swap cfg off", 0, 0, 1, 0, VEC, 8'hA5, 4'h9));
        i = idle(1, 1);
        drive(i, ex("R9 swap cfg on", 0, 0, 1, 1, VEC, 8'hA5, 4'h9));
        // R11 cold boot clears everything
        i = idle(1, 1); i.cold = 1;
        drive(i, ex("R11/R1 cold after lock", 0, 0, 0, 0, ROM_E, 8'h00, 4'h0));
        i = idle(1, 1); i.rd = 1;
        drive(i, ex("R4 second boot", 1, 1, 0, 0, VEC, 8'h00, 4'h0));
        i = idle(1, 1); i.idw = 1;
        drive(i, ex("R9 swap reg cleared", 1, 0, 1, 0, VEC, 8'h00, 4'h0));
        // R5 no secure stage
        i = idle(0, 1); i.cold = 1;
        drive(i, ex("R1 cold no secure", 0, 0, 0, 0, ROM_E, 8'h00, 4'h0));
        i = idle(0, 1); i.rd = 1;
        drive(i, ex("R5/R3 rom done no secure", 1, 0, 1, 0, VEC, 8'h00, 4'h0));
        i = idle(0, 1); i.fww = 1; i.fwd = 8'hFF; i.ksw = 1; i.ksd = 4'hF; i.sww = 1; i.swd = 1;
        drive(i, ex("R5 writes ignored", 0, 0, 1, 0, VEC, 8'h00, 4'h0));
        i = idle(0, 1); i.idw = 1;
        drive(i, ex("R10 init no secure", 0, 0, 1, 0, VEC, 8'h00, 4'h0));
        i = idle(0, 1);
        drive(i, ex("R5 steady", 0, 0, 1, 0, VEC, 8'h00, 4'h0));

        repeat (3) @(posedge clk);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule